// File: doc/BRIEF.md
# Accumulator ALU with Flag Update

This block is the arithmetic core beside an accumulator and a set of register pairs. It does five things. It adds two bytes, with or without an incoming carry. It ANDs two bytes. It adds two 16-bit words, with or without an incoming carry. It is purely combinational: the caller presents the operands, an operation code, a carry bit and the present flag byte, and reads back the result and the next flag byte in the same cycle.

Each operation has its own rule for every flag. Some flags are computed from the result. Some are forced to a constant. Some are copied through from the incoming flag byte. The 16-bit plain add is the one that preserves the most: it leaves sign, zero and parity/overflow as they were. The 16-bit add-with-carry recomputes all of them.

Top module: `acc_alu_top`

## Requirements
- R1: `op_sel` selects the operation: 0 = byte add, 1 = byte add-with-carry, 2 = byte AND, 3 = word add, 4 = word add-with-carry. Byte add returns `(opnd_a[7:0] + opnd_b[7:0]) mod 256` in `result[7:0]` with `result[15:8] = 0`. The upper operand bytes do not affect it.
- R2: Byte add-with-carry returns `(opnd_a[7:0] + opnd_b[7:0] + carry_in) mod 256`, zero-extended.
- R3: The flag byte holds sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. For ops 0 and 1, the flags are set as follows: sign is result bit 7; zero is set when the byte result is 0; half-carry is the carry out of bit 3; carry is the carry out of bit 7; subtract is 0.
- R4: For ops 0 and 1, parity/overflow is 1 exactly when both byte operands have the same sign and the result's sign differs from it.
- R5: Byte AND returns `opnd_a[7:0] & opnd_b[7:0]`, zero-extended. For AND, the flags are set as follows: sign is result bit 7; zero is set for a zero result; half-carry is 1; subtract is 0; carry is 0.
- R6: For AND, parity/overflow is 1 when the result has an even count of one bits and 0 when the count is odd.
- R7: Word add returns `(opnd_a + opnd_b) mod 65536`. For word add, the flags are set as follows: half-carry is the carry out of bit 11; carry is the carry out of bit 15; subtract is 0. Sign, zero and parity/overflow equal their `flags_in` values.
- R8: Word add-with-carry returns `(opnd_a + opnd_b + carry_in) mod 65536`. For word add-with-carry, the flags are set as follows: sign is bit 15; zero is set when all 16 bits are 0; half-carry is the carry out of bit 11; carry is the carry out of bit 15; parity/overflow is signed 16-bit overflow; subtract is 0.
- R9: Flag bits 5 and 3 always equal the same bits of `flags_in`.
- R10: Codes 5, 6 and 7 are idle: `result` is 0 and `flags_out` equals `flags_in`.
- R11: `carry_in` has no effect on ops 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code |
| opnd_a | input | 16 | Accumulator (low byte) or first register pair |
| opnd_b | input | 16 | Second operand (low byte for byte ops) |
| carry_in | input | 1 | Incoming carry for add-with-carry |
| flags_in | input | 8 | Present flag byte |
| result | output | 16 | Operation result, zero-extended for byte ops |
| flags_out | output | 8 | Next flag byte |

## Verification
The bench builds the block with its default widths: an 8-bit byte lane and a 16-bit word lane. With these widths, the half-carry boundaries at bits 3 and 11 can be hit with small hand-picked operands. So can the signed limits 0x7F/0x80 and 0x7FFF/0x8000, and the all-ones wrap to zero in both lanes. Incoming flag bytes with sign, zero, parity and the two spare bits set show which bits each operation preserves and which it overwrites.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam logic [2:0] OP_ADD8  = 3'd0;
  localparam logic [2:0] OP_ADC8  = 3'd1;
  localparam logic [2:0] OP_AND8  = 3'd2;
  localparam logic [2:0] OP_ADD16 = 3'd3;
  localparam logic [2:0] OP_ADC16 = 3'd4;

  localparam int FLAG_W = 8;
  localparam int FB_S   = 7;
  localparam int FB_Z   = 6;
  localparam int FB_H   = 4;
  localparam int FB_PV  = 2;
  localparam int FB_N   = 1;
  localparam int FB_C   = 0;

  // one when the count of set bits is even
  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction

  function automatic logic is_byte_add(input logic [2:0] op);
    return (op == OP_ADD8) || (op == OP_ADC8);
  endfunction

  function automatic logic is_word_add(input logic [2:0] op);
    return (op == OP_ADD16) || (op == OP_ADC16);
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    return op <= OP_ADC16;
  endfunction

endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hcarry,
  output logic         ovf
);
  // half-carry is taken from the nibble just below the top nibble
  localparam int LO_W = W - 4;

  logic [LO_W:0] lo_sum;
  logic [W:0]    full_sum;

  always_comb begin
    lo_sum   = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
    full_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  end

  assign sum    = full_sum[W-1:0];
  assign cout   = full_sum[W];
  assign hcarry = lo_sum[LO_W];
  assign ovf    = (a[W-1] ~^ b[W-1]) & (full_sum[W-1] ^ a[W-1]);

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import acc_alu_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic [2:0]        op,
  input  logic [BYTE_W-1:0] byte_sum,
  input  logic              byte_cy,
  input  logic              byte_hc,
  input  logic              byte_ovf,
  input  logic [BYTE_W-1:0] and_res,
  input  logic [WORD_W-1:0] word_sum,
  input  logic              word_cy,
  input  logic              word_hc,
  input  logic              word_ovf,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out
);

  always_comb begin
    flags_out = flags_in;
    unique case (op)
      OP_ADD8, OP_ADC8: begin
        flags_out[FB_S]  = byte_sum[BYTE_W-1];
        flags_out[FB_Z]  = ~|byte_sum;
        flags_out[FB_H]  = byte_hc;
        flags_out[FB_PV] = byte_ovf;
        flags_out[FB_N]  = 1'b0;
        flags_out[FB_C]  = byte_cy;
      end
      OP_AND8: begin
        flags_out[FB_S]  = and_res[BYTE_W-1];
        flags_out[FB_Z]  = ~|and_res;
        flags_out[FB_H]  = 1'b1;
        flags_out[FB_PV] = ~^and_res;
        flags_out[FB_N]  = 1'b0;
        flags_out[FB_C]  = 1'b0;
      end
      OP_ADD16: begin
        flags_out[FB_H]  = word_hc;
        flags_out[FB_N]  = 1'b0;
        flags_out[FB_C]  = word_cy;
      end
      OP_ADC16: begin
        flags_out[FB_S]  = word_sum[WORD_W-1];
        flags_out[FB_Z]  = ~|word_sum;
        flags_out[FB_H]  = word_hc;
        flags_out[FB_PV] = word_ovf;
        flags_out[FB_N]  = 1'b0;
        flags_out[FB_C]  = word_cy;
      end
      default: flags_out = flags_in;
    endcase
  end

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import acc_alu_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic [2:0]        op_sel,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic [7:0]        flags_in,
  output logic [WORD_W-1:0] result,
  output logic [7:0]        flags_out
);
  localparam int PAD_W = WORD_W - BYTE_W;

  // named internal events, observed by the checker
  logic [BYTE_W-1:0] byte_sum;
  logic              byte_cy;
  logic              byte_hc;
  logic              byte_ovf;
  logic [BYTE_W-1:0] and_res;
  logic [WORD_W-1:0] word_sum;
  logic              word_cy;
  logic              word_hc;
  logic              word_ovf;
  logic              byte_cin;
  logic              word_cin;

  assign byte_cin = (op_sel == OP_ADC8)  & carry_in;
  assign word_cin = (op_sel == OP_ADC16) & carry_in;
  assign and_res  = opnd_a[BYTE_W-1:0] & opnd_b[BYTE_W-1:0];

  acc_adder #(.W(BYTE_W)) u_byte_add (
    .a      (opnd_a[BYTE_W-1:0]),
    .b      (opnd_b[BYTE_W-1:0]),
    .cin    (byte_cin),
    .sum    (byte_sum),
    .cout   (byte_cy),
    .hcarry (byte_hc),
    .ovf    (byte_ovf)
  );

  acc_adder #(.W(WORD_W)) u_word_add (
    .a      (opnd_a),
    .b      (opnd_b),
    .cin    (word_cin),
    .sum    (word_sum),
    .cout   (word_cy),
    .hcarry (word_hc),
    .ovf    (word_ovf)
  );

  acc_flag_unit #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_flags (
    .op        (op_sel),
    .byte_sum  (byte_sum),
    .byte_cy   (byte_cy),
    .byte_hc   (byte_hc),
    .byte_ovf  (byte_ovf),
    .and_res   (and_res),
    .word_sum  (word_sum),
    .word_cy   (word_cy),
    .word_hc   (word_hc),
    .word_ovf  (word_ovf),
    .flags_in  (flags_in),
    .flags_out (flags_out)
  );

  always_comb begin
    if (is_byte_add(op_sel))       result = {{PAD_W{1'b0}}, byte_sum};
    else if (op_sel == OP_AND8)    result = {{PAD_W{1'b0}}, and_res};
    else if (is_word_add(op_sel))  result = word_sum;
    else                           result = '0;
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input logic [2:0]        op_sel,
  input logic [7:0]        flags_in,
  input logic [7:0]        flags_out,
  input logic [WORD_W-1:0] result,
  input logic              byte_ovf,
  input logic              word_ovf
);

  always_comb begin
    // R9
    spare_bits_chk: assert (flags_out[5] == flags_in[5] && flags_out[3] == flags_in[3])
      else $error("spare flag bits altered");
    if (op_known(op_sel)) begin
      // R3
      sub_clear_chk: assert (flags_out[FB_N] == 1'b0) else $error("subtract flag set");
    end
    if (is_byte_add(op_sel) || op_sel == OP_AND8) begin
      // R1
      upper_zero_chk: assert (result[WORD_W-1:BYTE_W] == '0) else $error("byte op upper bits");
    end
    if (is_byte_add(op_sel)) begin
      // R4
      byte_ovf_chk: assert (flags_out[FB_PV] == byte_ovf) else $error("byte overflow flag");
    end
    if (op_sel == OP_AND8) begin
      // R5
      and_flags_chk: assert (flags_out[FB_H] && !flags_out[FB_C]) else $error("AND H/C flags");
    end
    if (op_sel == OP_ADD16) begin
      // R7
      word_keep_chk: assert (flags_out[FB_S] == flags_in[FB_S] && flags_out[FB_Z] == flags_in[FB_Z]
                             && flags_out[FB_PV] == flags_in[FB_PV])
        else $error("word add altered kept flags");
    end
    if (op_sel == OP_ADC16) begin
      // R8
      word_zero_chk: assert (flags_out[FB_Z] == (result == '0) && flags_out[FB_PV] == word_ovf)
        else $error("word adc Z/PV");
    end
    if (!op_known(op_sel)) begin
      // R10
      idle_pass_chk: assert (flags_out == flags_in && result == '0) else $error("idle op changed state");
    end
  end

endmodule

bind acc_alu_top acc_alu_chk #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_chk (
  .op_sel    (op_sel),
  .flags_in  (flags_in),
  .flags_out (flags_out),
  .result    (result),
  .byte_ovf  (byte_ovf),
  .word_ovf  (word_ovf)
);

// File: tb/test_acc_alu_top.sv
module test_acc_alu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd7;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic        carry_in = 1'b0;
  logic [7:0]  flags_in = '0;
  logic [15:0] result;
  logic [7:0]  flags_out;
  int checks = 0;
  int errors = 0;
  int wd_cnt = 0;

  always #5 clk = ~clk;

  acc_alu_top i_acc_alu_top (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
    .flags_in(flags_in), .result(result), .flags_out(flags_out)
  );

  // bench's own statement of the requirements: returns {flags, result}
  function automatic logic [23:0] expect_of(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                                            input logic ci, input logic [7:0] fi);
    int ua, ub, c, s, hs, sa, sb, ss;
    logic [15:0] r;
    logic [7:0]  f;
    f = fi; r = '0;
    case (op)
      3'd0, 3'd1: begin
        c  = (op == 3'd1 && ci) ? 1 : 0;
        ua = int'(a[7:0]); ub = int'(b[7:0]);
        s  = ua + ub + c; hs = (ua % 16) + (ub % 16) + c;
        sa = (ua > 127) ? ua - 256 : ua; sb = (ub > 127) ? ub - 256 : ub; ss = sa + sb + c;
        r  = 16'(s % 256);
        f[7] = r[7]; f[6] = (r == 0); f[4] = (hs > 15); f[2] = (ss > 127) || (ss < -128);
        f[1] = 1'b0; f[0] = (s > 255);
      end
      3'd2: begin
        r = {8'h00, a[7:0] & b[7:0]};
        f[7] = r[7]; f[6] = (r == 0); f[4] = 1'b1; f[2] = ($countones(r) % 2 == 0);
        f[1] = 1'b0; f[0] = 1'b0;
      end
      3'd3, 3'd4: begin
        c  = (op == 3'd4 && ci) ? 1 : 0;
        ua = int'(a); ub = int'(b);
        s  = ua + ub + c; hs = (ua % 4096) + (ub % 4096) + c;
        r  = 16'(s % 65536);
        f[4] = (hs > 4095); f[1] = 1'b0; f[0] = (s > 65535);
        if (op == 3'd4) begin
          sa = (ua > 32767) ? ua - 65536 : ua; sb = (ub > 32767) ? ub - 65536 : ub; ss = sa + sb + c;
          f[7] = r[15]; f[6] = (r == 0); f[2] = (ss > 32767) || (ss < -32768);
        end
      end
      default: r = '0;
    endcase
    return {f, r};
  endfunction

  task automatic apply(input string req, input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input logic [7:0] fi);
    logic [23:0] exp;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci; flags_in = fi;
    #1;
    exp = expect_of(op, a, b, ci, fi);
    checks++;
    if ({flags_out, result} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h ci=%0b fi=%h: got res=%h flg=%h expected res=%h flg=%h",
               req, op, a, b, ci, fi, result, flags_out, exp[15:0], exp[23:16]);
    end
  endtask

  task automatic t_reset_idle;
    // R10: idle code with everything zero
    apply("R10", 3'd7, 16'h0000, 16'h0000, 1'b0, 8'h00);
    apply("R10", 3'd5, 16'h1234, 16'h4321, 1'b1, 8'hD7);
    apply("R10", 3'd6, 16'hFFFF, 16'hFFFF, 1'b1, 8'h28);
  endtask

  task automatic t_byte_add;
    apply("R1", 3'd0, 16'hAB12, 16'hCD34, 1'b0, 8'h00);   // upper bytes ignored
    apply("R3", 3'd0, 16'h000F, 16'h0001, 1'b0, 8'h00);   // half-carry out of bit 3
    apply("R3", 3'd0, 16'h00FF, 16'h0001, 1'b0, 8'hFF);   // zero and carry
    apply("R4", 3'd0, 16'h007F, 16'h0001, 1'b0, 8'h00);   // positive overflow
    apply("R4", 3'd0, 16'h0080, 16'h0080, 1'b0, 8'h00);   // negative overflow, carry, zero
    apply("R4", 3'd0, 16'h0050, 16'h00C0, 1'b0, 8'h00);   // mixed signs, no overflow
  endtask

  task automatic t_byte_adc;
    apply("R2", 3'd1, 16'h0010, 16'h0020, 1'b1, 8'h00);
    apply("R2", 3'd1, 16'h00FF, 16'h0000, 1'b1, 8'h00);   // carry alone wraps to zero
    apply("R3", 3'd1, 16'h0007, 16'h0008, 1'b1, 8'h00);   // carry in drives half-carry
    apply("R4", 3'd1, 16'h007F, 16'h0000, 1'b1, 8'h00);   // overflow from carry in
  endtask

  task automatic t_byte_and;
    apply("R5", 3'd2, 16'hFFF0, 16'h0F0F, 1'b1, 8'h01);   // clears carry
    apply("R5", 3'd2, 16'h00AA, 16'h0055, 1'b0, 8'h00);   // zero result
    apply("R6", 3'd2, 16'h0007, 16'h00FF, 1'b0, 8'h00);   // odd count
    apply("R6", 3'd2, 16'h0081, 16'h00FF, 1'b0, 8'h00);   // even count, sign
  endtask

  task automatic t_word_add;
    apply("R7", 3'd3, 16'h0FFF, 16'h0001, 1'b0, 8'hC4);   // half-carry out of bit 11, keeps S Z PV
    apply("R7", 3'd3, 16'hFFFF, 16'h0001, 1'b0, 8'h00);   // zero result but Z kept clear
    apply("R7", 3'd3, 16'h7FFF, 16'h0001, 1'b0, 8'h42);   // overflow not reported
    apply("R7", 3'd3, 16'h1234, 16'h1111, 1'b0, 8'h80);
  endtask

  task automatic t_word_adc;
    apply("R8", 3'd4, 16'h7FFF, 16'h0000, 1'b1, 8'h00);   // overflow via carry
    apply("R8", 3'd4, 16'hFFFF, 16'h0000, 1'b1, 8'hC4);   // zero, carry, H
    apply("R8", 3'd4, 16'h8000, 16'h8000, 1'b0, 8'h00);   // negative overflow
    apply("R8", 3'd4, 16'h1234, 16'h0100, 1'b1, 8'hFF);
  endtask

  task automatic t_spare_bits;
    apply("R9", 3'd0, 16'h0001, 16'h0002, 1'b0, 8'h28);
    apply("R9", 3'd2, 16'h00FF, 16'h00FF, 1'b0, 8'h20);
    apply("R9", 3'd4, 16'h0001, 16'h0001, 1'b1, 8'h08);
  endtask

  task automatic t_carry_ignored;
    apply("R11", 3'd0, 16'h00FF, 16'h0000, 1'b1, 8'h00);  // would wrap if used
    apply("R11", 3'd2, 16'h000F, 16'h0003, 1'b1, 8'h00);
    apply("R11", 3'd3, 16'hFFFF, 16'h0000, 1'b1, 8'h00);  // would wrap if used
  endtask

  always @(posedge clk) begin
    if (rst_n) wd_cnt <= wd_cnt + 1;
    if (wd_cnt > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_byte_add();
    t_byte_adc();
    t_byte_and();
    t_word_add();
    t_word_adc();
    t_spare_bits();
    t_carry_ignored();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule